// File: doc/BRIEF.md
# Melody Buffer Player

This block takes a short melody as a stream of 8-bit note codes, one code per cycle in which a receive-valid strobe is high, and keeps the codes in a 32-slot buffer. Once the buffer has been loaded, a start pulse plays the stored notes in slot order. For each note it drives a period count, which is the number of 12 MHz system clocks in one cycle of the pitch, and a square wave at 50% duty that can drive a buzzer directly.

While the melody plays, a freeze output tells the clock and temperature display to hold its values. A one-cycle done pulse marks the end of the melody. After that pulse the block goes back to loading and waits for the next melody.

Control runs as four named states. LOAD accepts bytes. It moves to READY when the end code 0xFF arrives, or when the byte for slot 30 arrives. READY moves to PLAY on start. PLAY moves to DONE when the current note code is 0xFF. DONE always moves back to LOAD on the next clock and rewinds the write pointer.

Top module: `melody_player`

## Requirements
- R1: While reset is held and on the first cycle after it, period is 0 and tone, freeze and done are all 0.
- R2: In LOAD, each byte with rx_valid high is written to the next slot, starting at slot 0. Loading completes on the cycle that stores 0xFF, or on the cycle that stores slot 30. Slot 31 always reads as 0xFF. Bytes that arrive outside LOAD are dropped.
- R3: A start pulse in LOAD has no effect. A start pulse in READY clears the play counter, and freeze is high on the next cycle.
- R4: The note index is bits [NOTE_SHIFT+4:NOTE_SHIFT] of the play counter, so each slot is held for 2^NOTE_SHIFT clocks. The default is 22, which gives about 0.35 s. The period output is registered and follows the slot being read by one clock.
- R5: The upper nibble of a code selects the octave: 0xA low, 0xB middle, 0xC high, 0xD highest. The lower nibble 1 to 7 selects the scale degree. Examples of the resulting periods are 0xA1 → 45872, 0xB1 → 22931, 0xC1 → 11478 and 0xD7 → 3036.
- R6: Any other code gives a period of 0, which is silence, and playback continues with the next slot.
- R7: Reading 0xFF gives a period of 0 and ends playback. Done is high for exactly the next cycle, and the block then returns to LOAD.
- R8: A 16-bit counter counts from 1 up to the period and then wraps to 1. Tone is registered high while the counter is below half the period and low otherwise. A period of 0 drives tone low.
- R9: Freeze is high in every PLAY cycle and in no other cycle. It is low in the DONE cycle.
- R10: A start pulse during PLAY does not restart the melody or change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Strobe that marks a received byte |
| rx_byte | input | 8 | Received note code |
| start | input | 1 | Request to play the loaded melody |
| period | output | 16 | Clocks per cycle of the current pitch (0 = silence) |
| tone | output | 1 | Square wave for the buzzer |
| freeze | output | 1 | Hold request for the display while playing |
| done | output | 1 | One-cycle pulse at the end of the melody |

## Verification
A behavioural model is compared with all four outputs on every clock. The bench targets the following cases, each paired with the failure it would expose:
- **Start while loading.** A design that accepted this start would play a half-written buffer.
- **31-byte load with no end code.** A design that did not force slot 31 to 0xFF would never raise done.
- **Unknown code in the middle of a melody.** This must give silence without ending playback.
- **Second start during playback.** This must not rewind the play counter.
- **Stray bytes after loading.** Bytes received in READY or PLAY must not overwrite slots.
- **Wrap of the tone counter.** This runs with the shortest period, and also across a change of period, so an off-by-one in the wrap or the half-period compare shows up as a tone edge one cycle out of place.

// File: rtl/mp_pkg.sv
package mp_pkg;

    localparam int PERIOD_W = 16;
    localparam logic [7:0] END_CODE = 8'hFF;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_READY = 2'd1,
        ST_PLAY  = 2'd2,
        ST_DONE  = 2'd3
    } mp_state_t;

    // Clocks per pitch cycle at 12 MHz; octave in the upper nibble, degree in the lower.
    function automatic logic [PERIOD_W-1:0] note_period(input logic [7:0] code);
        logic [PERIOD_W-1:0] p;
        case (code)
            8'hA1: p = 16'd45872;
            8'hA2: p = 16'd40858;
            8'hA3: p = 16'd36408;
            8'hA4: p = 16'd34364;
            8'hA5: p = 16'd30612;
            8'hA6: p = 16'd27273;
            8'hA7: p = 16'd24296;
            8'hB1: p = 16'd22931;
            8'hB2: p = 16'd20432;
            8'hB3: p = 16'd18201;
            8'hB4: p = 16'd17180;
            8'hB5: p = 16'd15306;
            8'hB6: p = 16'd13636;
            8'hB7: p = 16'd12148;
            8'hC1: p = 16'd11478;
            8'hC2: p = 16'd10215;
            8'hC3: p = 16'd9140;
            8'hC4: p = 16'd8598;
            8'hC5: p = 16'd7653;
            8'hC6: p = 16'd6818;
            8'hC7: p = 16'd6072;
            8'hD1: p = 16'd5730;
            8'hD2: p = 16'd5106;
            8'hD3: p = 16'd4548;
            8'hD4: p = 16'd4294;
            8'hD5: p = 16'd3826;
            8'hD6: p = 16'd3409;
            8'hD7: p = 16'd3036;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mp_loader.sv
module mp_loader
    import mp_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             rewind,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_code,
    output logic             load_last
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);
    localparam logic [IDX_W-1:0] FINAL_WR  = IDX_W'(SLOTS - 2);

    logic [IDX_W-1:0] wptr_q;
    logic [7:0]       slot_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (rewind) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wptr_q] <= wr_byte;
        end
    end

    // The last slot always reads as the end marker so playback terminates.
    assign rd_code   = (rd_idx == LAST_SLOT) ? END_CODE : slot_q[rd_idx];
    assign load_last = wr_en && ((wr_byte == END_CODE) || (wptr_q == FINAL_WR));

    p_wptr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wptr_q < LAST_SLOT));

endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
    import mp_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int NOTE_SHIFT = 22,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PC_W  = NOTE_SHIFT + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             start,
    input  logic             load_last,
    input  logic [7:0]       cur_code,
    output logic             wr_en,
    output logic             rewind,
    output logic             playing,
    output logic [IDX_W-1:0] play_idx,
    output logic             freeze,
    output logic             done
);

    mp_state_t state_q, state_d;
    logic [PC_W-1:0] pcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (rx_valid && load_last) state_d = ST_READY;
            ST_READY: if (start) state_d = ST_PLAY;
            ST_PLAY:  if (cur_code == END_CODE) state_d = ST_DONE;
            ST_DONE:  state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (state_q == ST_READY && start) begin
            pcnt_q <= '0;
        end else if (state_q == ST_PLAY) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        wr_en   = (state_q == ST_LOAD) && rx_valid;
        rewind  = (state_q == ST_DONE);
        playing = (state_q == ST_PLAY);
        freeze  = (state_q == ST_PLAY);
        done    = (state_q == ST_DONE);
    end

    assign play_idx = pcnt_q[PC_W-1 -: IDX_W];

    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && start) |=> (state_q != ST_PLAY));
    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAY && start && cur_code != END_CODE) |=>
            (state_q == ST_PLAY && pcnt_q == $past(pcnt_q) + 1'b1));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_play_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(freeze));
    p_freeze_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(freeze && done));

endmodule

// File: rtl/mp_tone.sv
module mp_tone
    import mp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                playing,
    input  logic [7:0]          code,
    output logic [PERIOD_W-1:0] period,
    output logic                tone
);

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic                tone_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) period_q <= '0;
        else        period_q <= playing ? note_period(code) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= PERIOD_W'(1);
            tone_q <= 1'b0;
        end else begin
            cnt_q  <= (cnt_q >= period_q) ? PERIOD_W'(1) : cnt_q + 1'b1;
            tone_q <= (period_q != '0) && (cnt_q < (period_q >> 1));
        end
    end

    assign period = period_q;
    assign tone   = tone_q;

    p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> !tone);

endmodule

// File: rtl/melody_player.sv
module melody_player
    import mp_pkg::*;
#(
    parameter int SLOTS      = 32,
    parameter int NOTE_SHIFT = 22,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        start,
    output logic [15:0] period,
    output logic        tone,
    output logic        freeze,
    output logic        done
);

    logic             wr_en, rewind, load_last, playing;
    logic [IDX_W-1:0] play_idx;
    logic [7:0]       cur_code;

    mp_loader #(.SLOTS(SLOTS)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (rx_byte),
        .rewind    (rewind),
        .rd_idx    (play_idx),
        .rd_code   (cur_code),
        .load_last (load_last)
    );

    mp_ctrl #(.SLOTS(SLOTS), .NOTE_SHIFT(NOTE_SHIFT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .start     (start),
        .load_last (load_last),
        .cur_code  (cur_code),
        .wr_en     (wr_en),
        .rewind    (rewind),
        .playing   (playing),
        .play_idx  (play_idx),
        .freeze    (freeze),
        .done      (done)
    );

    mp_tone u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .playing (playing),
        .code    (cur_code),
        .period  (period),
        .tone    (tone)
    );

endmodule

// File: tb/test_melody_player.sv
module test_melody_player;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 11;
    localparam int SL = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic start = 1'b0;
    logic [15:0] period;
    logic tone, freeze, done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    melody_player #(.SLOTS(SL), .NOTE_SHIFT(NS)) i_melody_player (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .start(start), .period(period), .tone(tone), .freeze(freeze), .done(done)
    );

    // Pitch table by (octave row, degree) as given in R5.
    int ptab [28] = '{45872, 40858, 36408, 34364, 30612, 27273, 24296,
                      22931, 20432, 18201, 17180, 15306, 13636, 12148,
                      11478, 10215, 9140, 8598, 7653, 6818, 6072,
                      5730, 5106, 4548, 4294, 3826, 3409, 3036};

    function automatic int ref_period(int code);
        int oct = code >> 4;
        int deg = code & 15;
        if (oct >= 10 && oct <= 13 && deg >= 1 && deg <= 7)
            return ptab[(oct - 10) * 7 + deg - 1];
        return 0;
    endfunction

    // Behavioural reference: 0 loading, 1 ready, 2 playing, 3 done.
    int m_state, m_wptr, m_per, m_cnt, m_pcnt;
    int m_buf [SL];
    bit m_tone;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_wptr = 0; m_per = 0; m_cnt = 1; m_pcnt = 0; m_tone = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
        end else begin
            int nt, nc, np, idx, code;
            nt = (m_per != 0 && m_cnt < m_per / 2) ? 1 : 0;
            nc = (m_cnt >= m_per) ? 1 : m_cnt + 1;
            np = 0;
            case (m_state)
                0: if (rx_valid) begin
                       m_buf[m_wptr] = rx_byte;
                       if (rx_byte == 8'hFF || m_wptr == SL - 2) m_state = 1;
                       m_wptr++;
                   end
                1: if (start) begin m_state = 2; m_pcnt = 0; end
                2: begin
                       idx = m_pcnt / (1 << NS);
                       code = (idx == SL - 1) ? 255 : m_buf[idx];
                       np = ref_period(code);
                       if (code == 255) m_state = 3;
                       m_pcnt++;
                   end
                default: begin m_state = 0; m_wptr = 0; end
            endcase
            m_tone = nt[0]; m_cnt = nc; m_per = np;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 period", period, 0);
            chk("R1 freeze", freeze, 0);
        end else begin
            chk("R4 R5 R6 period", period, m_per);
            chk("R8 tone", tone, m_tone);
            chk("R9 freeze", freeze, m_state == 2);
            chk("R7 done", done, m_state == 3);
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(int limit);
        int n = 0;
        while (done !== 1'b1 && n < limit) begin @(negedge clk); n++; end
        chk("R7 done seen", done, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 tone", tone, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 period after reset", period, 0);

        // R3: a start while loading is ignored
        kick();
        chk("R3 start in load", freeze, 0);
        send(8'hD7); send(8'hD7); send(8'h55); send(8'hA1); send(8'hFF);
        send(8'hC1);                       // R2: dropped in READY
        kick();
        chk("R3 playing", freeze, 1);
        repeat (100) @(negedge clk);
        kick();                            // R10: retrigger ignored
        chk("R10 still playing", freeze, 1);
        send(8'hB2);                       // R2: dropped in PLAY
        wait_done(6 * (1 << NS));
        @(negedge clk);
        chk("R9 freeze after done", freeze, 0);

        // Immediate end marker
        send(8'hFF);
        kick();
        wait_done(50);
        @(negedge clk);

        // R2: 31 bytes with no end marker; slot 31 forces termination
        for (int i = 0; i < 30; i++) send(8'hD1 + 8'(i % 7));
        kick();
        chk("R2 incomplete load", freeze, 0);
        send(8'hD7);
        kick();
        chk("R2 full load plays", freeze, 1);
        wait_done(33 * (1 << NS));
        @(negedge clk);

        // Period change with counter wrap
        send(8'hD7); send(8'h07); send(8'hD1); send(8'hFF);
        kick();
        wait_done(5 * (1 << NS));
        repeat (5) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule